// File: doc/BRIEF.md
# Multi-Channel Double-Edge PWM Generator

The block drives six pulse-width-modulated outputs from one free-running time base. A prescaler divides the clock into ticks, and a counter advances once per tick and returns to zero when it reaches the period value held in match slot 0. Match slots 1 to 6 set the pulse edges. Each channel runs in one of two modes. In single-edge mode the channel rises at the start of each period and falls at its own match. In double-edge mode it rises at the match of the slot below its own and falls at its own match. This lets one slot set the falling edge of one channel and the rising edge of the next.

Software writes match values into shadow slots through a simple write port. A shadow value reaches the comparators only at a period boundary, and only if its latch request bit was set before that boundary. Mode and output-enable bits take effect on the clock after the write.

Top module: `pwm_dual_edge`

## Requirements
- R1: After reset all outputs are low, the counter is 0, every shadow and active match slot holds 0, the prescale value is 0, all channels are in single-edge mode and all outputs are disabled.
- R2: A tick occurs on a clock when the prescale counter is greater than or equal to the prescale value, so with value P there is one tick every P+1 clocks. On a tick the counter increments, except that when it already equals active slot 0 it returns to 0. The counter holds between ticks.
- R3: With its mode bit clear, channel n (1 to 6) goes high on the tick where the counter returns to 0. It goes low on the tick where the counter takes the value of active slot n.
- R4: With its mode bit set, channel n goes high on the tick where the counter takes the value of active slot n-1. It goes low on the tick where the counter takes the value of active slot n.
- R5: Writing address k (0 to 6) loads shadow slot k only. On a tick that returns the counter to 0, every slot whose latch request bit is set copies its shadow value into its active value, and that request bit clears. Writing address 10 ORs wr_data[6:0] into the request bits, with bit k for slot k.
- R6: When a channel's rising and falling events fall on the same tick, the falling event wins. A match value above active slot 0 never produces an event.
- R7: Address 7 holds the prescale value. Address 8 holds the mode bits, with bit n-1 for channel n (1 = double-edge). Address 9 holds the enable bits, with bit n-1 for channel n. A cleared enable bit forces that output low. Mode and enable changes apply from the clock after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 32 | Register write data |
| pwm_o | output | 6 | PWM outputs, bit n-1 is channel n |

## Verification
A corrupted counter or prescale state shows up as a wrong period within one period. Every channel's duty then shifts at the same time, so it is seen on all outputs together. A wrong active match slot, or a latch request that was lost or applied twice, changes the duty of one or two neighbouring channels from the first boundary on. A wrong edge level stays wrong until that channel's next event. The bench compares every output on every clock with a behavioural model. It also measures the high time of each channel over whole periods in the corner cases: coincident edges, a match above the period, a shadow value written but not latched, and a prescaled time base.

// File: rtl/pwm_dual_edge_pkg.sv
package pwm_dual_edge_pkg;

    // Register offsets placed after the match slots
    localparam int unsigned OFS_PRESCALE = 0;
    localparam int unsigned OFS_MODE     = 1;
    localparam int unsigned OFS_ENABLE   = 2;
    localparam int unsigned OFS_LATCH    = 3;
    localparam int unsigned NUM_CFG_REGS = 4;

    typedef enum logic {
        EDGE_SINGLE = 1'b0,
        EDGE_DOUBLE = 1'b1
    } edge_mode_e;

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int unsigned PRE_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PRE_W-1:0] limit,
    output logic             tick
);

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = (st_q.cnt >= limit);
        if (tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + PRE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] count_q,
    output logic [CNT_W-1:0] count_next,
    output logic             wrap
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tb_state_t;

    tb_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        wrap = tick && (st_q.cnt == period);
        if (wrap) begin
            st_d.cnt = '0;
        end else if (tick) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
        count_next = st_d.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_q = st_q.cnt;

endmodule

// File: rtl/pwm_regfile.sv
module pwm_regfile
    import pwm_dual_edge_pkg::*;
#(
    parameter int unsigned NUM_CH = 6,
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned ADDR_W = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [ADDR_W-1:0]                wr_addr,
    input  logic [CNT_W-1:0]                 wr_data,
    input  logic                             boundary,
    output logic [NUM_CH:0][CNT_W-1:0]       active,
    output logic [CNT_W-1:0]                 prescale,
    output logic [NUM_CH-1:0]                mode,
    output logic [NUM_CH-1:0]                enable
);

    localparam int unsigned NUM_MATCH  = NUM_CH + 1;
    localparam logic [ADDR_W-1:0] A_PRE = ADDR_W'(NUM_MATCH + OFS_PRESCALE);
    localparam logic [ADDR_W-1:0] A_MOD = ADDR_W'(NUM_MATCH + OFS_MODE);
    localparam logic [ADDR_W-1:0] A_ENA = ADDR_W'(NUM_MATCH + OFS_ENABLE);
    localparam logic [ADDR_W-1:0] A_LAT = ADDR_W'(NUM_MATCH + OFS_LATCH);

    typedef struct packed {
        logic [NUM_MATCH-1:0][CNT_W-1:0] shadow;
        logic [NUM_MATCH-1:0][CNT_W-1:0] active;
        logic [NUM_MATCH-1:0]            pend;
        logic [CNT_W-1:0]                presc;
        logic [NUM_CH-1:0]               mode;
        logic [NUM_CH-1:0]               en;
    } regs_t;

    regs_t rg_d, rg_q;

    always_comb begin
        rg_d = rg_q;
        // boundary transfer uses the shadow contents held before this clock
        if (boundary) begin
            for (int i = 0; i < NUM_MATCH; i++) begin
                if (rg_q.pend[i]) begin
                    rg_d.active[i] = rg_q.shadow[i];
                    rg_d.pend[i]   = 1'b0;
                end
            end
        end
        if (wr_en) begin
            for (int i = 0; i < NUM_MATCH; i++) begin
                if (wr_addr == ADDR_W'(i)) begin
                    rg_d.shadow[i] = wr_data;
                end
            end
            if (wr_addr == A_PRE) begin
                rg_d.presc = wr_data;
            end
            if (wr_addr == A_MOD) begin
                rg_d.mode = wr_data[NUM_CH-1:0];
            end
            if (wr_addr == A_ENA) begin
                rg_d.en = wr_data[NUM_CH-1:0];
            end
            if (wr_addr == A_LAT) begin
                rg_d.pend = rg_d.pend | wr_data[NUM_MATCH-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q <= '0;
        end else begin
            rg_q <= rg_d;
        end
    end

    assign active   = rg_q.active;
    assign prescale = rg_q.presc;
    assign mode     = rg_q.mode;
    assign enable   = rg_q.en;

endmodule

// File: rtl/pwm_edge_unit.sv
module pwm_edge_unit
    import pwm_dual_edge_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wrap,
    input  logic [CNT_W-1:0] count_next,
    input  edge_mode_e       mode,
    input  logic [CNT_W-1:0] rise_match,
    input  logic [CNT_W-1:0] fall_match,
    output logic             level
);

    typedef struct packed {
        logic lvl;
    } edge_state_t;

    edge_state_t st_d, st_q;
    logic        set_ev;
    logic        clr_ev;

    always_comb begin
        st_d   = st_q;
        clr_ev = tick && (count_next == fall_match);
        if (mode == EDGE_DOUBLE) begin
            set_ev = tick && (count_next == rise_match);
        end else begin
            set_ev = wrap;
        end
        // falling event has priority over a coincident rising event
        if (clr_ev) begin
            st_d.lvl = 1'b0;
        end else if (set_ev) begin
            st_d.lvl = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level = st_q.lvl;

endmodule

// File: rtl/pwm_dual_edge.sv
module pwm_dual_edge
    import pwm_dual_edge_pkg::*;
#(
    parameter int unsigned NUM_CH = 6,
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned ADDR_W = $clog2(NUM_CH + 1 + NUM_CFG_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [NUM_CH-1:0] pwm_o
);

    logic [NUM_CH:0][CNT_W-1:0] active;
    logic [CNT_W-1:0]           prescale;
    logic [NUM_CH-1:0]          mode;
    logic [NUM_CH-1:0]          enable;
    logic                       tick;
    logic                       wrap;
    logic [CNT_W-1:0]           count_q;
    logic [CNT_W-1:0]           count_next;
    logic [CNT_W-1:0]           period;
    logic [NUM_CH-1:0]          level;

    assign period = active[0];

    pwm_regfile #(
        .NUM_CH (NUM_CH),
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W)
    ) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .boundary (wrap),
        .active   (active),
        .prescale (prescale),
        .mode     (mode),
        .enable   (enable)
    );

    pwm_prescaler #(
        .PRE_W (CNT_W)
    ) i_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .limit (prescale),
        .tick  (tick)
    );

    pwm_timebase #(
        .CNT_W (CNT_W)
    ) i_tb (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .period     (period),
        .count_q    (count_q),
        .count_next (count_next),
        .wrap       (wrap)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        pwm_edge_unit #(
            .CNT_W (CNT_W)
        ) i_edge (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick       (tick),
            .wrap       (wrap),
            .count_next (count_next),
            .mode       (edge_mode_e'(mode[c])),
            .rise_match (active[c]),
            .fall_match (active[c+1]),
            .level      (level[c])
        );
    end

    assign pwm_o = level & enable;

endmodule

// File: rtl/pwm_dual_edge_chk.sv
module pwm_dual_edge_chk #(
    parameter int unsigned NUM_CH = 6,
    parameter int unsigned CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  period,
    input logic [NUM_CH-1:0] level
);

    AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        count <= period); // R2

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count)); // R2

    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count == period) |=> (count == '0)); // R2

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count != period) |=> (count == $past(count) + CNT_W'(1))); // R2

    AST_LEVEL_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(level)); // R3

endmodule

bind pwm_dual_edge pwm_dual_edge_chk #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W)
) i_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .count  (count_q),
    .period (period),
    .level  (level)
);

// File: tb/test_pwm_dual_edge.sv
`timescale 1ns/1ps
module test_pwm_dual_edge;

    localparam int NCH = 6;
    localparam int NM  = NCH + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [5:0]  pwm_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    pwm_dual_edge i_pwm_dual_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pwm_o   (pwm_o)
    );

    always #10 clk = ~clk;

    // behavioural reference model
    logic [31:0] m_sh [NM];
    logic [31:0] m_act [NM];
    logic [NM-1:0] m_pend;
    logic [31:0] m_presc, m_pre, m_cnt;
    logic [NCH-1:0] m_mode, m_en, m_lvl;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NM; i++) begin
                m_sh[i] = 0;
                m_act[i] = 0;
            end
            m_pend = 0; m_presc = 0; m_pre = 0; m_cnt = 0;
            m_mode = 0; m_en = 0; m_lvl = 0;
        end else begin
            bit tk, wr;
            logic [31:0] nxt;
            tk = (m_pre >= m_presc);
            m_pre = tk ? 0 : m_pre + 1;
            wr = tk && (m_cnt == m_act[0]);
            nxt = wr ? 0 : (tk ? m_cnt + 1 : m_cnt);
            for (int c = 0; c < NCH; c++) begin
                bit s, r;
                r = tk && (nxt == m_act[c+1]);
                s = m_mode[c] ? (tk && nxt == m_act[c]) : wr;
                if (r) m_lvl[c] = 1'b0;
                else if (s) m_lvl[c] = 1'b1;
            end
            m_cnt = nxt;
            if (wr) begin
                for (int i = 0; i < NM; i++) begin
                    if (m_pend[i]) begin
                        m_act[i] = m_sh[i];
                        m_pend[i] = 1'b0;
                    end
                end
            end
            if (wr_en) begin
                if (wr_addr < NM) m_sh[wr_addr] = wr_data;
                else if (wr_addr == 7) m_presc = wr_data;
                else if (wr_addr == 8) m_mode = wr_data[NCH-1:0];
                else if (wr_addr == 9) m_en = wr_data[NCH-1:0];
                else if (wr_addr == 10) m_pend = m_pend | wr_data[NM-1:0];
            end
        end
    end

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (!rst_n) begin
            n_checks++;
            if (pwm_o !== '0) begin
                n_fail++;
                $display("FAIL R1 outputs in reset: actual %b expected %b", pwm_o, 6'b0);
            end
        end else begin
            for (int c = 0; c < NCH; c++) begin
                n_checks++;
                if (pwm_o[c] !== (m_lvl[c] & m_en[c])) begin
                    n_fail++;
                    $display("FAIL %s ch%0d at cycle %0d: actual %b expected %b",
                             m_mode[c] ? "R4" : "R3", c + 1, cycles, pwm_o[c],
                             m_lvl[c] & m_en[c]);
                end
            end
        end
    end

    task automatic write_reg(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // count high clocks of one channel over a window
    task automatic expect_high(input int ch, input int win, input int exp, input string tag);
        int hi;
        hi = 0;
        for (int i = 0; i < win; i++) begin
            @(negedge clk);
            if (pwm_o[ch-1] === 1'b1) hi++;
        end
        n_checks++;
        if (hi != exp) begin
            n_fail++;
            $display("FAIL %s ch%0d high clocks: actual %0d expected %0d", tag, ch, hi, exp);
        end
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        n_checks++;
        if (pwm_o !== '0) begin
            n_fail++;
            $display("FAIL R1 after reset: actual %b expected %b", pwm_o, 6'b0);
        end
        // R5: load shadows, request latch of all slots
        write_reg(0, 9);
        write_reg(1, 4);
        write_reg(2, 2);
        write_reg(3, 7);
        write_reg(4, 12);
        write_reg(5, 5);
        write_reg(6, 5);
        write_reg(8, 32'h34);   // R7: ch3, ch5, ch6 double-edge
        write_reg(9, 32'h3F);
        write_reg(10, 32'h7F);
        wait_clk(30);
        expect_high(1, 10, 4, "R3");
        expect_high(2, 10, 2, "R3");
        expect_high(3, 10, 5, "R4");
        expect_high(4, 10, 10, "R6 above period");
        expect_high(5, 10, 0, "R6 above period");
        expect_high(6, 10, 0, "R6 coincident");
        // R7: disabled output stays low
        write_reg(9, 32'h3E);
        expect_high(1, 10, 0, "R7");
        expect_high(2, 10, 2, "R7");
        write_reg(9, 32'h3F);
        // R5: shadow write without latch has no effect
        write_reg(1, 6);
        wait_clk(25);
        expect_high(1, 10, 4, "R5 unlatched");
        write_reg(10, 32'h02);
        wait_clk(25);
        expect_high(1, 10, 6, "R5 latched");
        // R2: prescale of 1 doubles the period
        write_reg(7, 1);
        wait_clk(40);
        expect_high(1, 20, 12, "R2");
        expect_high(2, 20, 4, "R2");
        // R4: ch2 to double-edge, rise at slot1=6, fall at slot2=2
        write_reg(8, 32'h36);
        wait_clk(40);
        expect_high(2, 20, 12, "R4");
        wait_clk(5);
        done = 1'b1;
    end

    initial begin
        while (!done && cycles < 100000) @(negedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule